// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This peripheral is a bus-programmed watchdog. A down-counter of `CNT_W` bits steps once on each slow tick enable (nominally a 32768 Hz rate, so software converts milliseconds to ticks as ms × 32768 / 1000). Software programs a reload value and copies it into the counter with a load strobe. The new value takes effect at that edge, not at the next expiry. Counting starts only when software sets both the counter-run bit of the control register and the separate update-enable register. A warning register sets how many ticks before expiry the interrupt is raised. Software programs it before the load strobe.

At expiry, the block does one of two things, chosen by the reset-request enable. With the enable clear, the counter reloads from the reload register and keeps running, so the block acts as a periodic early-warning timer. With the enable set, the block raises an active-low reset request and holds it until its own hardware reset. The interrupt output is the raw event flag gated by an interrupt-enable register. Any write to the clear register drops the raw flag.

The sequencing lives in a three-state machine:
- **HALT**: not counting, the state after reset.
- **COUNT**: ticks step the counter.
- **TRIP**: the reset request is asserted. This state is left only by hardware reset.

The transitions are:
- **start**: HALT→COUNT when both enables are set.
- **stop**: COUNT→HALT when either enable is cleared.
- **fire**: COUNT→TRIP on a tick that finds the count at zero while reset requests are enabled.
- **rearm**: a tick that finds the count at zero with reset requests disabled reloads the counter and stays in COUNT.

Top module: `wdt_early_warn`

Register word offsets:

| Offset | Register | Bits |
|---|---|---|
| 0x00 | control | bit 2 counter-run, bit 1 bus-clock enable, bit 0 tick-clock enable (stored only) |
| 0x04 | reload | full width |
| 0x08 | load strobe | bit 0 |
| 0x0C | reset-request enable | bit 0 |
| 0x10 | interrupt enable | bit 0 |
| 0x14 | raw interrupt | bit 0 |
| 0x18 | masked interrupt | bit 0 |
| 0x1C | clear | any value |
| 0x20 | update enable | bit 0 |
| 0x24 | count | full width |
| 0x28 | reset-request status | bit 0, 1 = idle |
| 0x2C | warning distance | full width |

## Requirements
- R1: After reset:
  - every register reads 0, except the reset-request status at 0x28, which reads 1;
  - `irq_o` is 0;
  - `rst_req_n_o` is 1.
- R2: The writable registers read back what was written:
  - the control register at 0x00 keeps only bits 2:0, so writing 0xFF reads 7;
  - the reload register at 0x04 and the warning register at 0x2C keep the full value;
  - the enables at 0x0C, 0x10 and 0x20 keep bit 0;
  - the strobe register at 0x08 and the clear register at 0x1C read 0.
- R3: A write to 0x08 with bit 0 set copies the reload register into the counter on the same edge, so the count read at 0x24 shows it from the next cycle. A write to 0x08 with bit 0 clear leaves the count unchanged.
- R4: Ticks are counted under these rules:
  - a tick decrements the count by one only in COUNT;
  - COUNT is entered one cycle after both control bit 2 and update-enable bit 0 are 1;
  - a tick is ignored while either enable is 0.
- R5: A counted tick that finds the count equal to the warning register sets the raw flag. The raw flag reads at 0x14 bit 0 whatever the interrupt enable is.
- R6: `irq_o` and the masked register at 0x18 both equal the raw flag ANDed with interrupt-enable bit 0.
- R7: Any write to 0x1C clears the raw flag. A warning hit on the same edge takes precedence.
- R8: If reset requests are disabled, a counted tick that finds the count at 0 reloads the reload value, and `rst_req_n_o` stays 1.
- R9: If reset-request enable bit 0 is 1, a counted tick that finds the count at 0 drives `rst_req_n_o` low, and 0x28 reads 0. Both stay that way until `rst_n`, whatever further ticks or load strobes arrive.
- R10: With an undisturbed run, the raw flag rises exactly as many counted ticks before the reset request as the warning register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid during a read access |
| tick_i | input | 1 | One-cycle slow tick enable |
| irq_o | output | 1 | Masked early-warning interrupt |
| rst_req_n_o | output | 1 | Active-low reset request |

## Verification
Each result has a fixed latency, and every check is placed at it:
- A register write takes effect on the clock edge of its access phase, and the read data is combinational during a read access. Reads are therefore sampled in the access phase after that edge.
- A load strobe or a tick changes the count, the raw flag, `irq_o` and `rst_req_n_o` on the edge where it is high.
- After enabling, one extra cycle passes before the state machine is in COUNT.

The bench drives the strobe, the tick and the enables on falling edges and samples after the next falling edge. This keeps every sample one full edge past its cause. The run-time checks match each interrupt and reset-request edge to the tick that caused it.

// File: rtl/wdt_ew_pkg.sv
package wdt_ew_pkg;
    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] A_CTRL  = 12'h000;
    localparam logic [OFS_W-1:0] A_RELOAD = 12'h004;
    localparam logic [OFS_W-1:0] A_STROBE = 12'h008;
    localparam logic [OFS_W-1:0] A_RSTEN = 12'h00C;
    localparam logic [OFS_W-1:0] A_IEN   = 12'h010;
    localparam logic [OFS_W-1:0] A_RAW   = 12'h014;
    localparam logic [OFS_W-1:0] A_MASKD = 12'h018;
    localparam logic [OFS_W-1:0] A_CLR   = 12'h01C;
    localparam logic [OFS_W-1:0] A_UPD   = 12'h020;
    localparam logic [OFS_W-1:0] A_COUNT = 12'h024;
    localparam logic [OFS_W-1:0] A_RQST  = 12'h028;
    localparam logic [OFS_W-1:0] A_WARN  = 12'h02C;

    localparam int CTRL_W   = 3;
    localparam int RUN_BIT  = 2;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TRIP  = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_ew_regs.sv
module wdt_ew_regs
    import wdt_ew_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [OFS_W-1:0]  paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              run,
    output logic              rst_en,
    output logic              ien,
    output logic [CNT_W-1:0]  reload,
    output logic [CNT_W-1:0]  warn,
    output logic              load_stb,
    output logic              clr_stb,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              raw,
    input  logic              irq,
    input  logic              rst_req_n
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              upd_q;
    logic              wr;

    assign wr       = psel && penable && pwrite;
    assign load_stb = wr && (paddr == A_STROBE) && pwdata[0];
    assign clr_stb  = wr && (paddr == A_CLR);
    assign run      = ctrl_q[RUN_BIT] && upd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            upd_q  <= 1'b0;
            rst_en <= 1'b0;
            ien    <= 1'b0;
            reload <= '0;
            warn   <= '0;
        end else if (wr) begin
            unique case (paddr)
                A_CTRL:   ctrl_q <= pwdata[CTRL_W-1:0];
                A_RELOAD: reload <= pwdata[CNT_W-1:0];
                A_RSTEN:  rst_en <= pwdata[0];
                A_IEN:    ien    <= pwdata[0];
                A_UPD:    upd_q  <= pwdata[0];
                A_WARN:   warn   <= pwdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (paddr)
                A_CTRL:   prdata = DATA_W'(ctrl_q);
                A_RELOAD: prdata = DATA_W'(reload);
                A_RSTEN:  prdata = DATA_W'(rst_en);
                A_IEN:    prdata = DATA_W'(ien);
                A_RAW:    prdata = DATA_W'(raw);
                A_MASKD:  prdata = DATA_W'(irq);
                A_UPD:    prdata = DATA_W'(upd_q);
                A_COUNT:  prdata = DATA_W'(cnt);
                A_RQST:   prdata = DATA_W'(rst_req_n);
                A_WARN:   prdata = DATA_W'(warn);
                default:  prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_ew_core.sv
module wdt_ew_core
    import wdt_ew_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             rst_en,
    input  logic             ien,
    input  logic             load_stb,
    input  logic             clr_stb,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] warn,
    output logic [CNT_W-1:0] cnt,
    output logic             raw,
    output logic             irq,
    output logic             rst_req_n,
    output wd_state_e        state_o
);
    wd_state_e state_q, state_d;
    logic      step, at_zero, warn_hit;

    assign step     = (state_q == ST_COUNT) && run && tick;
    assign at_zero  = (cnt == '0);
    assign warn_hit = step && (cnt == warn);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions: start, stop, fire (rearm stays in COUNT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run) state_d = ST_COUNT;
            ST_COUNT: begin
                if (step && at_zero && rst_en) state_d = ST_TRIP;
                else if (!run)                 state_d = ST_HALT;
            end
            ST_TRIP:  state_d = ST_TRIP;
            default:  state_d = ST_HALT;
        endcase
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_stb) begin
            cnt <= reload;
        end else if (step) begin
            if (!at_zero)     cnt <= cnt - CNT_W'(1);
            else if (!rst_en) cnt <= reload;
        end
    end

    // raw early-warning flag, set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        raw <= 1'b0;
        else if (warn_hit) raw <= 1'b1;
        else if (clr_stb)  raw <= 1'b0;
    end

    // outputs
    always_comb begin
        irq       = raw && ien;
        rst_req_n = (state_q != ST_TRIP);
        state_o   = state_q;
    end
endmodule

// File: rtl/wdt_early_warn.sv
module wdt_early_warn
    import wdt_ew_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [OFS_W-1:0]  paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              tick_i,
    output logic              irq_o,
    output logic              rst_req_n_o
);
    logic             cfg_run, cfg_rst_en, cfg_ien, load_stb, clr_stb, raw_irq;
    logic [CNT_W-1:0] cfg_reload, cfg_warn, cnt;
    wd_state_e        core_state;

    wdt_ew_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .run(cfg_run), .rst_en(cfg_rst_en), .ien(cfg_ien),
        .reload(cfg_reload), .warn(cfg_warn), .load_stb(load_stb),
        .clr_stb(clr_stb), .cnt(cnt), .raw(raw_irq), .irq(irq_o),
        .rst_req_n(rst_req_n_o)
    );

    wdt_ew_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .run(cfg_run),
        .rst_en(cfg_rst_en), .ien(cfg_ien), .load_stb(load_stb),
        .clr_stb(clr_stb), .reload(cfg_reload), .warn(cfg_warn),
        .cnt(cnt), .raw(raw_irq), .irq(irq_o), .rst_req_n(rst_req_n_o),
        .state_o(core_state)
    );
endmodule

// File: rtl/wdt_early_warn_chk.sv
module wdt_early_warn_chk
    import wdt_ew_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run,
    input logic             rst_en,
    input logic             load_stb,
    input logic             clr_stb,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] warn,
    input logic [CNT_W-1:0] cnt,
    input logic             raw,
    input logic             rst_req_n,
    input wd_state_e        state
);
    logic counted;
    assign counted = (state == ST_COUNT) && run && tick;

    p_load_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> cnt == $past(reload));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!counted && !load_stb) |=> $stable(cnt));

    p_step_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (counted && cnt != '0 && !load_stb) |=> cnt == $past(cnt) - CNT_W'(1));

    p_warn_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (counted && cnt == warn) |=> raw);

    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !(counted && cnt == warn)) |=> !raw);

    p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (counted && cnt == '0 && !rst_en && !load_stb)
            |=> (cnt == $past(reload)) && rst_req_n);

    p_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (counted && cnt == '0 && rst_en) |=> !rst_req_n);

    p_trip_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_n |=> !rst_req_n);
endmodule

bind wdt_early_warn wdt_early_warn_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .run(cfg_run),
    .rst_en(cfg_rst_en), .load_stb(load_stb), .clr_stb(clr_stb),
    .reload(cfg_reload), .warn(cfg_warn), .cnt(cnt), .raw(raw_irq),
    .rst_req_n(rst_req_n_o), .state(core_state)
);

// File: tb/wdt_early_warn_bench.sv
module wdt_early_warn_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick_i = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o, rst_req_n_o;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    wdt_early_warn u_wdt_early_warn (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .tick_i(tick_i), .irq_o(irq_o), .rst_req_n_o(rst_req_n_o)
    );

    // {write, req, addr, data, expected}
    localparam int NV = 19;
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 4'd1, 8'h00, 32'd0,  32'd0},   // R1 control
        {1'b0, 4'd1, 8'h28, 32'd0,  32'd1},   // R1 request status idle
        {1'b0, 4'd1, 8'h24, 32'd0,  32'd0},   // R1 count
        {1'b1, 4'd2, 8'h04, 32'd10, 32'd0},
        {1'b0, 4'd2, 8'h04, 32'd0,  32'd10},  // R2 reload
        {1'b1, 4'd2, 8'h2C, 32'd3,  32'd0},
        {1'b0, 4'd2, 8'h2C, 32'd0,  32'd3},   // R2 warning
        {1'b1, 4'd3, 8'h08, 32'd1,  32'd0},
        {1'b0, 4'd3, 8'h24, 32'd0,  32'd10},  // R3 strobe copies
        {1'b0, 4'd2, 8'h08, 32'd0,  32'd0},   // R2 strobe reads 0
        {1'b1, 4'd2, 8'h00, 32'hFF, 32'd0},
        {1'b0, 4'd2, 8'h00, 32'd0,  32'd7},   // R2 control 3 bits
        {1'b1, 4'd2, 8'h00, 32'd7,  32'd0},
        {1'b1, 4'd2, 8'h20, 32'd1,  32'd0},
        {1'b0, 4'd2, 8'h20, 32'd0,  32'd1},   // R2 update enable
        {1'b1, 4'd2, 8'h10, 32'd1,  32'd0},
        {1'b0, 4'd2, 8'h10, 32'd0,  32'd1},   // R2 irq enable
        {1'b0, 4'd5, 8'h14, 32'd0,  32'd0},   // R5 no event yet
        {1'b0, 4'd2, 8'h0C, 32'd0,  32'd0}    // R2 reset enable
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog timeout got running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq_o after reset", 32'(irq_o), 32'd0);
        check("R1 rst_req_n_o after reset", 32'(rst_req_n_o), 32'd1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76])
                bus_write({4'h0, VEC[i][71:64]}, VEC[i][63:32]);
            else begin
                bus_read({4'h0, VEC[i][71:64]}, rd);
                check($sformatf("R%0d table entry %0d", VEC[i][75:72], i), rd, VEC[i][31:0]);
            end
        end

        // count 10, warning 3: seven ticks reach 3 with no event
        for (int k = 1; k <= 7; k++) begin
            do_tick();
            bus_read(12'h024, rd);
            check("R4 decrement per tick", rd, 32'(10 - k));
        end
        check("R5 no early raw", 32'(irq_o), 32'd0);
        do_tick();   // finds count 3
        check("R6 irq_o on warning", 32'(irq_o), 32'd1);
        bus_read(12'h014, rd); check("R5 raw set", rd, 32'd1);
        bus_read(12'h018, rd); check("R6 masked set", rd, 32'd1);

        bus_write(12'h010, 32'd0);
        check("R6 irq_o masked off", 32'(irq_o), 32'd0);
        bus_read(12'h018, rd); check("R6 masked off", rd, 32'd0);
        bus_read(12'h014, rd); check("R5 raw ignores enable", rd, 32'd1);
        bus_write(12'h01C, 32'd0);
        bus_read(12'h014, rd); check("R7 clear drops raw", rd, 32'd0);
        bus_read(12'h01C, rd); check("R2 clear reads 0", rd, 32'd0);
        bus_write(12'h010, 32'd1);

        do_tick(); do_tick();
        bus_read(12'h024, rd); check("R4 count reaches zero", rd, 32'd0);
        do_tick();
        bus_read(12'h024, rd); check("R8 reload on expiry", rd, 32'd10);
        check("R8 no reset request", 32'(rst_req_n_o), 32'd1);

        bus_write(12'h020, 32'd0);
        do_tick();
        bus_read(12'h024, rd); check("R4 tick ignored, update off", rd, 32'd10);
        bus_write(12'h020, 32'd1);
        bus_write(12'h000, 32'd3);
        do_tick();
        bus_read(12'h024, rd); check("R4 tick ignored, run bit off", rd, 32'd10);
        bus_write(12'h000, 32'd7);
        do_tick();
        bus_read(12'h024, rd); check("R4 resumes", rd, 32'd9);

        bus_write(12'h004, 32'd5);
        bus_write(12'h008, 32'd0);
        bus_read(12'h024, rd); check("R3 strobe bit0 clear no load", rd, 32'd9);
        bus_write(12'h008, 32'd1);
        bus_read(12'h024, rd); check("R3 immediate load", rd, 32'd5);

        bus_write(12'h00C, 32'd1);
        bus_read(12'h00C, rd); check("R2 reset enable", rd, 32'd1);
        begin
            int raw_at, trip_at;
            raw_at = 0; trip_at = 0;
            for (int t = 1; t <= 6; t++) begin
                do_tick();
                if (irq_o && raw_at == 0) raw_at = t;
                if (!rst_req_n_o && trip_at == 0) trip_at = t;
            end
            check("R5 warning on third tick", 32'(raw_at), 32'd3);
            check("R9 request on sixth tick", 32'(trip_at), 32'd6);
            check("R10 distance equals warning", 32'(trip_at - raw_at), 32'd3);
        end
        bus_read(12'h028, rd); check("R9 status reads 0", rd, 32'd0);
        do_tick();
        bus_write(12'h008, 32'd1);
        do_tick();
        check("R9 request held", 32'(rst_req_n_o), 32'd0);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9 released by rst_n", 32'(rst_req_n_o), 32'd1);
        rst_n = 1'b1;
        bus_read(12'h028, rd); check("R1 status after reset", rd, 32'd1);
        bus_read(12'h000, rd); check("R1 control after reset", rd, 32'd0);
        bus_read(12'h024, rd); check("R1 count after reset", rd, 32'd0);

        done = 1'b1;
        finish_run();
    end
endmodule